// File: doc/BRIEF.md
# Host Data-Port DMA Engine

This block lets a host move bytes or 16-bit words between itself and the local buffer memory of a network controller through one data port. The host first programs a 16-bit transfer address and a 16-bit transfer count, one byte at a time. It also programs the first and stop pages of a circular buffer region. Every access to the data port then reads or writes memory at the current address. After the access the address advances by the access width and the count shrinks by it. When the address reaches the stop page, it is folded back to the first page.

When the count runs out, the engine sets a completion flag in an interrupt status register. That register has a matching enable mask and is cleared by writing ones to it. Other units of the controller may set the low six status bits through event inputs. Memory is split into two windows: a small low window at address zero and a packet window at a parameter base. Any access outside both windows reads as all ones, and a write there is dropped.

Top module: `rdma_port_engine`

## Requirements
- R1: With the width flag (register 9 bit 0) at 0, each data-port access moves one byte at the current address and advances the address by 1. A read returns the byte in dp_rdata[7:0] with the upper byte 0. dp_rdata shows the data at the current address before the read strobe.
- R2: With the width flag at 1, each access moves a 16-bit word. Address bit 0 is ignored, the low byte lives at the even address (little-endian), and the address advances by 2.
- R3: After an access, an advanced address equal to stop page (register 2) times 256 is replaced by first page (register 1) times 256.
- R4: When the count is greater than the width, an access reduces it by the width. Otherwise the count becomes 0 and status bit 6 is set.
- R5: A data-port write while the count is 0 changes neither memory, address nor count. Reads are always carried out.
- R6: Valid addresses are those below LOW_BYTES and those in [PMEM_BASE, PMEM_BASE+PMEM_BYTES). Elsewhere a read returns 0x00FF (byte) or 0xFFFF (word), and a write is dropped without aliasing onto a valid location.
- R7: A command write (register 0) with bit 0 clear, with bit 3 or bit 4 set, and with the count at 0 sets status bit 6 at once. With bit 0 set it does not.
- R8: Writing register 7 clears every one of status bits 6..0 that is written as 1. Status bit 7 is not touched by such a write. Bit 7 is cleared by a command write with bit 0 clear.
- R9: irq is high exactly when some bit of status[6:0] AND mask (register 8) is set. Status bit 7 never raises irq.
- R10: Address (registers 3 low, 4 high) and count (5 low, 6 high) are written one byte at a time. A byte write leaves the other byte unchanged, and all four read back.
- R11: A high evt_set[k] sets status bit k (k = 0..5). If a set and a clear reach the same bit in the same cycle, the set wins.
- R12: After reset, address = 0, count = 0, status = 0x80, mask = 0 and width flag = 0. First page = PMEM_BASE/256, stop page = (PMEM_BASE+PMEM_BYTES)/256, and irq = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_sel (combinational) |
| dp_wr | input | 1 | Data-port write strobe |
| dp_rd | input | 1 | Data-port read strobe (advances the transfer) |
| dp_wdata | input | 16 | Data-port write data |
| dp_rdata | output | 16 | Data at the current transfer address |
| evt_set | input | 6 | Status set events from other units |
| irq | output | 1 | Interrupt request |

## Verification
Some rules are checked by the assertions on every cycle. These are the count step and clamp with its completion flag, the page wrap, and write-one-to-clear. They also cover the clearing of the reset-indicator bit, the completion set on an empty-count command, event priority, the silence of irq under a zero mask, and the freeze of address and count on a write at zero count. Other results appear only in the bench's scenarios. Those are the memory contents, little-endian byte order, the ignored low address bit in word mode, all-ones reads outside the windows, and the absence of aliasing for dropped writes.

// File: rtl/rdma_pkg.sv
`timescale 1ns/1ps
package rdma_pkg;

  localparam int RD_AW = 16;
  localparam int RD_CW = 16;
  localparam int RD_PGW = RD_AW - 8;

  typedef enum logic [3:0] {
    RG_CMD   = 4'd0,
    RG_FIRST = 4'd1,
    RG_STOP  = 4'd2,
    RG_ALO   = 4'd3,
    RG_AHI   = 4'd4,
    RG_CLO   = 4'd5,
    RG_CHI   = 4'd6,
    RG_STAT  = 4'd7,
    RG_MASK  = 4'd8,
    RG_CFG   = 4'd9
  } reg_sel_e;

  localparam int CMD_HALT = 0;
  localparam int CMD_RD   = 3;
  localparam int CMD_WR   = 4;
  localparam int ST_DONE  = 6;
  localparam int ST_RST   = 7;

  function automatic logic [RD_AW-1:0] step_of(input logic wide);
    return wide ? RD_AW'(2) : RD_AW'(1);
  endfunction

  function automatic logic [RD_AW-1:0] addr_after(input logic [RD_AW-1:0] a,
                                                  input logic wide,
                                                  input logic [RD_PGW-1:0] first_pg,
                                                  input logic [RD_PGW-1:0] stop_pg);
    logic [RD_AW-1:0] s;
    s = a + step_of(wide);
    if (s == {stop_pg, 8'h00}) s = {first_pg, 8'h00};
    return s;
  endfunction

  function automatic logic cnt_expires(input logic [RD_CW-1:0] c, input logic wide);
    return c <= RD_CW'(step_of(wide));
  endfunction

  function automatic logic [RD_CW-1:0] cnt_after(input logic [RD_CW-1:0] c, input logic wide);
    return cnt_expires(c, wide) ? '0 : c - RD_CW'(step_of(wide));
  endfunction

  function automatic logic in_window(input logic [RD_AW-1:0] a, input int lo_bytes,
                                     input int base, input int span);
    int ai;
    ai = int'(a);
    return (ai < lo_bytes) || ((ai >= base) && (ai < base + span));
  endfunction

endpackage

// File: rtl/rdma_step.sv
`timescale 1ns/1ps
module rdma_step
  import rdma_pkg::*;
(
  input  logic [RD_AW-1:0]  cur_addr,
  input  logic [RD_CW-1:0]  cur_cnt,
  input  logic              wide,
  input  logic [RD_PGW-1:0] first_pg,
  input  logic [RD_PGW-1:0] stop_pg,
  output logic [RD_AW-1:0]  nxt_addr,
  output logic [RD_CW-1:0]  nxt_cnt,
  output logic              expire
);
  always_comb begin
    nxt_addr = addr_after(cur_addr, wide, first_pg, stop_pg);
    nxt_cnt  = cnt_after(cur_cnt, wide);
    expire   = cnt_expires(cur_cnt, wide);
  end
endmodule

// File: rtl/rdma_mem.sv
`timescale 1ns/1ps
module rdma_mem
  import rdma_pkg::*;
#(
  parameter int LOW_BYTES  = 32,
  parameter int PMEM_BASE  = 16384,
  parameter int PMEM_BYTES = 512
) (
  input  logic             clk,
  input  logic [RD_AW-1:0] addr,
  input  logic             wide,
  input  logic             we,
  input  logic [15:0]      wdata,
  output logic [15:0]      rdata,
  output logic             hit
);
  localparam int LOW_HALF = LOW_BYTES / 2;
  localparam int PK_HALF  = PMEM_BYTES / 2;
  localparam int LOW_IW   = $clog2(LOW_HALF);
  localparam int PK_IW    = $clog2(PK_HALF);

  logic             in_low;
  logic [LOW_IW-1:0] lidx;
  logic [PK_IW-1:0]  pidx;
  logic [1:0][7:0]   lane_q;

  assign in_low = int'(addr) < LOW_BYTES;
  assign hit    = in_window(addr, LOW_BYTES, PMEM_BASE, PMEM_BYTES);
  assign lidx   = LOW_IW'(addr >> 1);
  assign pidx   = PK_IW'((addr - RD_AW'(PMEM_BASE)) >> 1);

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    logic [7:0] low_bank [LOW_HALF];
    logic [7:0] pk_bank  [PK_HALF];
    logic       lane_we;
    logic [7:0] lane_wd;

    assign lane_we = we && hit && (wide || (addr[0] == ln[0]));
    assign lane_wd = wide ? wdata[8*ln +: 8] : wdata[7:0];

    always_ff @(posedge clk) begin
      if (lane_we) begin
        if (in_low) low_bank[lidx] <= lane_wd;
        else        pk_bank[pidx]  <= lane_wd;
      end
    end

    assign lane_q[ln] = in_low ? low_bank[lidx] : pk_bank[pidx];
  end

  always_comb begin
    if (!hit)       rdata = wide ? 16'hFFFF : 16'h00FF;
    else if (wide)  rdata = {lane_q[1], lane_q[0]};
    else            rdata = {8'h00, addr[0] ? lane_q[1] : lane_q[0]};
  end
endmodule

// File: rtl/rdma_regs.sv
`timescale 1ns/1ps
module rdma_regs
  import rdma_pkg::*;
#(
  parameter logic [RD_PGW-1:0] FIRST_RST = 8'h40,
  parameter logic [RD_PGW-1:0] STOP_RST  = 8'h42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              dma_go,
  input  logic [RD_AW-1:0]  nxt_addr,
  input  logic [RD_CW-1:0]  nxt_cnt,
  input  logic              dma_expire,
  input  logic [5:0]        evt_set,
  output logic [RD_AW-1:0]  cur_addr,
  output logic [RD_CW-1:0]  cur_cnt,
  output logic              wide,
  output logic [RD_PGW-1:0] first_pg,
  output logic [RD_PGW-1:0] stop_pg,
  output logic              irq
);
  logic [7:0]        cmd_q, stat_q, mask_q;
  logic [RD_PGW-1:0] first_q, stop_q;
  logic [RD_AW-1:0]  addr_q;
  logic [RD_CW-1:0]  cnt_q;
  logic              wide_q;

  // named internal events
  logic wr_cmd, wr_alo, wr_ahi, wr_clo, wr_chi, wr_stat, kick, done_set;
  logic [6:0] st_clr, st_set;

  assign wr_cmd  = reg_wr && (reg_sel == RG_CMD);
  assign wr_alo  = reg_wr && (reg_sel == RG_ALO);
  assign wr_ahi  = reg_wr && (reg_sel == RG_AHI);
  assign wr_clo  = reg_wr && (reg_sel == RG_CLO);
  assign wr_chi  = reg_wr && (reg_sel == RG_CHI);
  assign wr_stat = reg_wr && (reg_sel == RG_STAT);
  assign kick    = wr_cmd && !reg_wdata[CMD_HALT] &&
                   (reg_wdata[CMD_RD] || reg_wdata[CMD_WR]) && (cnt_q == '0);
  assign done_set = (dma_go && dma_expire) || kick;
  assign st_clr  = wr_stat ? reg_wdata[6:0] : 7'h00;
  assign st_set  = {done_set, evt_set};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= 8'h00;
      first_q <= FIRST_RST;
      stop_q  <= STOP_RST;
      addr_q  <= '0;
      cnt_q   <= '0;
      stat_q  <= 8'h80;
      mask_q  <= 8'h00;
      wide_q  <= 1'b0;
    end else begin
      if (wr_cmd) cmd_q <= reg_wdata;
      if (reg_wr && reg_sel == RG_FIRST) first_q <= reg_wdata;
      if (reg_wr && reg_sel == RG_STOP)  stop_q  <= reg_wdata;
      if (reg_wr && reg_sel == RG_MASK)  mask_q  <= reg_wdata;
      if (reg_wr && reg_sel == RG_CFG)   wide_q  <= reg_wdata[0];

      if (wr_alo)      addr_q <= {addr_q[RD_AW-1:8], reg_wdata};
      else if (wr_ahi) addr_q <= {reg_wdata, addr_q[7:0]};
      else if (dma_go) addr_q <= nxt_addr;

      if (wr_clo)      cnt_q <= {cnt_q[RD_CW-1:8], reg_wdata};
      else if (wr_chi) cnt_q <= {reg_wdata, cnt_q[7:0]};
      else if (dma_go) cnt_q <= nxt_cnt;

      stat_q[6:0] <= (stat_q[6:0] & ~st_clr) | st_set;
      if (wr_cmd && !reg_wdata[CMD_HALT]) stat_q[ST_RST] <= 1'b0;
    end
  end

  always_comb begin
    case (reg_sel)
      RG_CMD:   reg_rdata = cmd_q;
      RG_FIRST: reg_rdata = first_q;
      RG_STOP:  reg_rdata = stop_q;
      RG_ALO:   reg_rdata = addr_q[7:0];
      RG_AHI:   reg_rdata = addr_q[RD_AW-1:8];
      RG_CLO:   reg_rdata = cnt_q[7:0];
      RG_CHI:   reg_rdata = cnt_q[RD_CW-1:8];
      RG_STAT:  reg_rdata = stat_q;
      RG_MASK:  reg_rdata = mask_q;
      RG_CFG:   reg_rdata = {7'h00, wide_q};
      default:  reg_rdata = 8'h00;
    endcase
  end

  assign cur_addr = addr_q;
  assign cur_cnt  = cnt_q;
  assign wide     = wide_q;
  assign first_pg = first_q;
  assign stop_pg  = stop_q;
  assign irq      = |(stat_q[6:0] & mask_q[6:0]);

  // R4: count shrinks by the width while above it
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_go && !wr_clo && !wr_chi && cnt_q > RD_CW'(wide_q ? 2 : 1))
    |=> (cnt_q == $past(cnt_q) - RD_CW'($past(wide_q) ? 2 : 1)));

  // R4: count clamps to zero and flags completion
  p_cnt_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_go && !wr_clo && !wr_chi && cnt_q <= RD_CW'(wide_q ? 2 : 1))
    |=> (cnt_q == '0 && stat_q[ST_DONE]));

  // R3: landing on the stop page folds back to the first page
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_go && !wr_alo && !wr_ahi && (addr_q + RD_AW'(wide_q ? 2 : 1)) == {stop_q, 8'h00})
    |=> (addr_q == {$past(first_q), 8'h00}));

  // R8: written ones clear low status bits when nothing sets them
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !dma_go && evt_set == 6'h00)
    |=> ((stat_q[6:0] & $past(reg_wdata[6:0])) == 7'h00));

  // R8: reset indicator drops on a running command
  p_rst_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !reg_wdata[CMD_HALT]) |=> !stat_q[ST_RST]);

  // R7: a transfer command with an empty count completes at once
  p_kick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !reg_wdata[CMD_HALT] && reg_wdata[CMD_WR] && cnt_q == '0) |=> stat_q[ST_DONE]);

  // R11: events always land
  p_evt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != 6'h00) |=> ((stat_q[5:0] & $past(evt_set)) == $past(evt_set)));

  // R9: no enabled bit, no interrupt
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[6:0] == 7'h00) |-> !irq);
endmodule

// File: rtl/rdma_port_engine.sv
`timescale 1ns/1ps
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int LOW_BYTES  = 32,
  parameter int PMEM_BASE  = 16384,
  parameter int PMEM_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        dp_wr,
  input  logic        dp_rd,
  input  logic [15:0] dp_wdata,
  output logic [15:0] dp_rdata,
  input  logic [5:0]  evt_set,
  output logic        irq
);
  localparam logic [RD_PGW-1:0] FIRST_PG = RD_PGW'(PMEM_BASE >> 8);
  localparam logic [RD_PGW-1:0] STOP_PG  = RD_PGW'((PMEM_BASE + PMEM_BYTES) >> 8);

  logic [RD_AW-1:0]  cur_addr, nxt_addr;
  logic [RD_CW-1:0]  cur_cnt, nxt_cnt;
  logic [RD_PGW-1:0] first_pg, stop_pg;
  logic              wide, expire, mem_hit;
  logic              acc_rd, acc_wr, dma_go;

  assign acc_rd = dp_rd && !dp_wr;
  assign acc_wr = dp_wr && (cur_cnt != '0);
  assign dma_go = acc_rd || acc_wr;

  rdma_regs #(.FIRST_RST(FIRST_PG), .STOP_RST(STOP_PG)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dma_go(dma_go), .nxt_addr(nxt_addr), .nxt_cnt(nxt_cnt), .dma_expire(expire),
    .evt_set(evt_set), .cur_addr(cur_addr), .cur_cnt(cur_cnt), .wide(wide),
    .first_pg(first_pg), .stop_pg(stop_pg), .irq(irq)
  );

  rdma_step u_step (
    .cur_addr(cur_addr), .cur_cnt(cur_cnt), .wide(wide),
    .first_pg(first_pg), .stop_pg(stop_pg),
    .nxt_addr(nxt_addr), .nxt_cnt(nxt_cnt), .expire(expire)
  );

  rdma_mem #(.LOW_BYTES(LOW_BYTES), .PMEM_BASE(PMEM_BASE), .PMEM_BYTES(PMEM_BYTES)) u_mem (
    .clk(clk), .addr(cur_addr), .wide(wide), .we(acc_wr),
    .wdata(dp_wdata), .rdata(dp_rdata), .hit(mem_hit)
  );

  // R5: a port write at zero count leaves the transfer state alone
  p_idle_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_wr && cur_cnt == '0 && !reg_wr) |=> ($stable(cur_addr) && $stable(cur_cnt)));

  // R6: nothing is written outside the windows; the write strobe still advances state
  p_oob_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !mem_hit && !reg_wr) |=> (cur_cnt != $past(cur_cnt) || $past(cur_cnt) == '0));
endmodule

// File: tb/rdma_port_engine_bench.sv
`timescale 1ns/1ps
module rdma_port_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_sel;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        dp_wr, dp_rd;
  logic [15:0] dp_wdata, dp_rdata;
  logic [5:0]  evt_set;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  rdma_port_engine u_rdma_port_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_wr(dp_wr), .dp_rd(dp_rd),
    .dp_wdata(dp_wdata), .dp_rdata(dp_rdata), .evt_set(evt_set), .irq(irq)
  );

  localparam logic [1:0] K_RW = 2'd0;  // register write
  localparam logic [1:0] K_PW = 2'd1;  // data-port write
  localparam logic [1:0] K_PR = 2'd2;  // check dp_rdata, then read strobe
  localparam logic [1:0] K_RR = 2'd3;  // check register read

  function automatic logic [41:0] mkv(input logic [1:0] k, input logic [3:0] rq,
                                      input logic [3:0] a, input logic [15:0] d,
                                      input logic [15:0] e);
    return {k, rq, a, d, e};
  endfunction

  localparam int NV = 96;
  localparam logic [41:0] VEC [NV] = '{
    mkv(K_RW,0,0,16'h22,0),   mkv(K_RR,8,7,0,16'h00),                 // R8 cmd clears bit 7
    mkv(K_RW,0,3,16'h00,0),   mkv(K_RW,0,4,16'h40,0),
    mkv(K_RW,0,5,16'h03,0),   mkv(K_RW,0,6,16'h00,0),
    mkv(K_PW,0,0,16'h11,0),   mkv(K_PW,0,0,16'h22,0),   mkv(K_PW,0,0,16'h33,0),
    mkv(K_RR,1,3,0,16'h03),                                            // R1 byte advance
    mkv(K_RR,4,5,0,16'h00),   mkv(K_RR,4,7,0,16'h40),                 // R4 clamp + flag
    mkv(K_PW,0,0,16'h44,0),
    mkv(K_RR,5,3,0,16'h03),   mkv(K_RR,5,5,0,16'h00),                 // R5 ignored write
    mkv(K_RW,0,7,16'h40,0),   mkv(K_RR,8,7,0,16'h00),                 // R8 w1c
    mkv(K_RW,0,3,16'h00,0),   mkv(K_RW,0,5,16'h03,0),
    mkv(K_PR,1,0,0,16'h0011), mkv(K_PR,1,0,0,16'h0022), mkv(K_PR,1,0,0,16'h0033), // R1
    mkv(K_RR,1,3,0,16'h03),
    mkv(K_RW,0,9,16'h01,0),   mkv(K_RW,0,7,16'h7F,0),
    mkv(K_RW,0,3,16'h10,0),   mkv(K_RW,0,5,16'h04,0),
    mkv(K_PW,0,0,16'hBEEF,0), mkv(K_PW,0,0,16'hCAFE,0),
    mkv(K_RR,2,3,0,16'h14),   mkv(K_RR,4,7,0,16'h40),                 // R2 step 2, R4
    mkv(K_RW,0,9,16'h00,0),   mkv(K_RW,0,3,16'h10,0),   mkv(K_RW,0,5,16'h02,0),
    mkv(K_PR,2,0,0,16'h00EF), mkv(K_PR,2,0,0,16'h00BE),               // R2 little-endian
    mkv(K_RW,0,9,16'h01,0),   mkv(K_RW,0,3,16'h13,0),   mkv(K_RW,0,5,16'h02,0),
    mkv(K_PR,2,0,0,16'hCAFE), mkv(K_RR,2,3,0,16'h15),                 // R2 bit 0 ignored
    mkv(K_RW,0,7,16'h7F,0),   mkv(K_RW,0,3,16'h20,0),   mkv(K_RW,0,5,16'h03,0),
    mkv(K_PW,0,0,16'h1234,0),
    mkv(K_RR,4,5,0,16'h01),   mkv(K_RR,4,7,0,16'h00),                 // R4 3 -> 1
    mkv(K_PW,0,0,16'h5678,0),
    mkv(K_RR,4,5,0,16'h00),   mkv(K_RR,4,7,0,16'h40),                 // R4 1 -> 0
    mkv(K_RW,0,9,16'h00,0),   mkv(K_RW,0,2,16'h41,0),
    mkv(K_RW,0,3,16'hFF,0),   mkv(K_RW,0,5,16'h02,0),
    mkv(K_PW,0,0,16'h00A1,0),
    mkv(K_RR,3,4,0,16'h40),   mkv(K_RR,3,3,0,16'h00),                 // R3 wrap
    mkv(K_PW,0,0,16'h00A2,0),
    mkv(K_RW,0,3,16'h00,0),   mkv(K_RW,0,5,16'h01,0),
    mkv(K_PR,3,0,0,16'h00A2),                                          // R3 data at first page
    mkv(K_RW,0,2,16'h42,0),   mkv(K_RW,0,3,16'h00,0),
    mkv(K_RW,0,4,16'h01,0),   mkv(K_RW,0,5,16'h01,0),
    mkv(K_PR,6,0,0,16'h00FF),                                          // R6 byte hole
    mkv(K_RW,0,9,16'h01,0),   mkv(K_RW,0,4,16'h02,0),   mkv(K_RW,0,5,16'h02,0),
    mkv(K_PR,6,0,0,16'hFFFF),                                          // R6 word hole
    mkv(K_RW,0,9,16'h00,0),   mkv(K_RW,0,4,16'h00,0),
    mkv(K_RW,0,3,16'h05,0),   mkv(K_RW,0,5,16'h01,0),
    mkv(K_PW,0,0,16'h005A,0),
    mkv(K_RW,0,3,16'h25,0),   mkv(K_RW,0,5,16'h01,0),
    mkv(K_PW,0,0,16'h0077,0),
    mkv(K_RW,0,3,16'h05,0),   mkv(K_RW,0,5,16'h01,0),
    mkv(K_PR,6,0,0,16'h005A),                                          // R6 no alias
    mkv(K_RW,0,7,16'h7F,0),   mkv(K_RW,0,0,16'h0A,0),
    mkv(K_RR,7,7,0,16'h40),                                            // R7 kick
    mkv(K_RW,0,7,16'h40,0),   mkv(K_RW,0,0,16'h09,0),
    mkv(K_RR,7,7,0,16'h00),                                            // R7 halted, no kick
    mkv(K_RW,0,3,16'h34,0),   mkv(K_RW,0,4,16'h12,0),   mkv(K_RW,0,3,16'h56,0),
    mkv(K_RR,10,4,0,16'h12),  mkv(K_RR,10,3,0,16'h56),                // R10 address bytes
    mkv(K_RW,0,6,16'hAB,0),   mkv(K_RW,0,5,16'hCD,0),
    mkv(K_RR,10,6,0,16'hAB),  mkv(K_RR,10,5,0,16'hCD)                 // R10 count bytes
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regw(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic regr(input string tag, input logic [3:0] a, input logic [7:0] e);
    @(negedge clk);
    reg_sel = a;
    #1 chk(tag, {8'h00, reg_rdata}, {8'h00, e});
  endtask

  task automatic portw(input logic [15:0] d);
    @(negedge clk);
    dp_wdata = d; dp_wr = 1'b1;
    @(negedge clk);
    dp_wr = 1'b0;
  endtask

  task automatic portr(input string tag, input logic [15:0] e);
    @(negedge clk);
    #1 chk(tag, dp_rdata, e);
    dp_rd = 1'b1;
    @(negedge clk);
    dp_rd = 1'b0;
  endtask

  task automatic irq_is(input string tag, input logic e);
    @(negedge clk);
    #1 chk(tag, {15'h0, irq}, {15'h0, e});
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog (R1..all) actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 4'h0; reg_wdata = 8'h00;
    dp_wr = 1'b0; dp_rd = 1'b0; dp_wdata = 16'h0; evt_set = 6'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    regr("R12 addr lo", 4'd3, 8'h00);
    regr("R12 addr hi", 4'd4, 8'h00);
    regr("R12 cnt lo", 4'd5, 8'h00);
    regr("R12 cnt hi", 4'd6, 8'h00);
    regr("R12 status", 4'd7, 8'h80);
    regr("R12 mask", 4'd8, 8'h00);
    regr("R12 width", 4'd9, 8'h00);
    regr("R12 first page", 4'd1, 8'h40);
    regr("R12 stop page", 4'd2, 8'h42);
    irq_is("R12 irq", 1'b0);

    // R9 bit 7 never raises irq
    regw(4'd8, 8'h80);
    irq_is("R9 bit7 masked in", 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec %0d", v[39:36], i);
      case (v[41:40])
        K_RW: regw(v[35:32], v[23:16]);
        K_PW: portw(v[31:16]);
        K_PR: portr(tag, v[15:0]);
        default: regr(tag, v[35:32], v[7:0]);
      endcase
    end

    // R9 irq follows status AND mask
    regw(4'd5, 8'h00);
    regw(4'd6, 8'h00);
    regw(4'd8, 8'h40);
    irq_is("R9 idle", 1'b0);
    regw(4'd0, 8'h12);
    irq_is("R9 raised", 1'b1);
    regw(4'd7, 8'h40);
    irq_is("R9 cleared", 1'b0);

    // R11 events set status
    @(negedge clk); evt_set = 6'h04;
    @(negedge clk); evt_set = 6'h00;
    regr("R11 event bit2", 4'd7, 8'h04);
    regw(4'd8, 8'h04);
    irq_is("R9 event irq", 1'b1);
    @(negedge clk);
    reg_sel = 4'd7; reg_wdata = 8'h04; reg_wr = 1'b1; evt_set = 6'h04;
    @(negedge clk);
    reg_wr = 1'b0; evt_set = 6'h00;
    regr("R11 set beats clear", 4'd7, 8'h04);
    regw(4'd7, 8'h04);
    regr("R8 clear after event", 4'd7, 8'h00);

    finish_run();
  end
endmodule